// File: doc/BRIEF.md
# Serial Controller Interrupt Identification

This block decides, on every clock, which of five interrupt causes a register-compatible serial controller reports. It returns the identification byte that a read of the identification register would see, and it drives a registered interrupt request. The block takes in the enable bits, the receive error flags, the receive FIFO fill level, the FIFO trigger selection, the character time and the modem control bits. It holds three pieces of its own state: a flag that says a transmit-empty event is pending, a counter that measures how long received data has gone unread, and the modem status byte. In loopback mode it creates the modem status byte from the modem control outputs.

The surrounding controller sends strobes for the events that change this state: a byte leaving the holding buffer for the shift register, a write to the holding register, a read of the identification register, a read of the receive buffer, a push into the receive FIFO, and a read of the modem status. Input pins for the external modem lines and the data path itself belong to other blocks.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0xC1, the modem status byte is 0x00 and the request is low.
- R2: When enable bit 2 is set and any of the four error flags (overrun, parity, framing, break) is set, the code is 0x6. This source outranks every other source.
- R3: When enable bit 0 is set, the data-ready flag is set and the FIFO count is at or above the trigger level, the code is 0x4. A trigger select of 0, 1, 2 or 3 gives a level of 1, 4, 8 or 14 entries.
- R4: The timeout counter adds one on each clock while data-ready is set. It holds its value while data-ready is clear. A receive buffer read or a FIFO push clears it, and the clear wins over the increment. When enable bit 0 is set and the counter is at least TO_MULT times the character time, the code is 0xC. This source ranks below received data.
- R5: A holding-to-shift transfer sets the pending flag. A holding write or an identification read clears it. If a set and a clear arrive in the same clock, the set wins. When enable bit 1 is set, the holding-empty status is set and the flag is pending, the code is 0x2. This source ranks below timeout.
- R6: When enable bit 3 is set and any of modem status bits 3:0 is set, the code is 0x0. This source has the lowest rank. With no source active the code is 0x1.
- R7: The identification byte always has bits 7:6 at 1 and bits 5:4 at 0, with the code in bits 3:0.
- R8: The request goes high one clock after the code leaves 0x1, and it goes low one clock after the code returns to 0x1.
- R9: With control bit 4 (loopback) set, each clock copies control bit 3 into status bit 7, control bit 2 into status bit 6, control bit 0 into status bit 5 and control bit 1 into status bit 4.
- R10: In loopback, status bits 3, 1 and 0 are set when the new level in status bit 7, 5 or 4 differs from the old one. Status bit 2 is set only when status bit 6 falls from 1 to 0. Once set, a delta bit stays set until the status byte is cleared.
- R11: A modem status read clears the whole status byte at the next clock, and the read wins over the loopback update. Outside loopback the status byte does not change, except through such a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Enables: 0 rx data/timeout, 1 holding empty, 2 line status, 3 modem |
| lsr_err_i | input | 4 | Overrun, parity, framing and break flags |
| data_ready_i | input | 1 | Receive data-ready status |
| thr_empty_i | input | 1 | Holding register empty status |
| rx_count_i | input | CNT_W | Receive FIFO entries held |
| trig_sel_i | input | 2 | FIFO trigger select |
| char_time_i | input | CT_W | Character time in clocks |
| mcr_i | input | 5 | Modem control: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback |
| hold_load_i | input | 1 | Byte moved from the holding buffer to the shift register |
| hold_write_i | input | 1 | Holding register write |
| iir_read_i | input | 1 | Identification register read |
| rbr_read_i | input | 1 | Receive buffer read |
| rx_push_i | input | 1 | Character pushed into the receive FIFO |
| msr_read_i | input | 1 | Modem status read |
| iir_o | output | 8 | Identification byte |
| msr_o | output | 8 | Modem status byte |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH 16, CT_W 6 and TO_MULT 2. The small multiplier and the short character times (1 to 7 clocks) mean a timeout can fire within a few clocks, so the random phase often shows timeout competing with received data and with the holding-empty source. A 16-entry count lets the random phase reach all four trigger levels, including counts just below and just above the 14-entry level.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_MODEM   = 4'h0,
    IID_NONE    = 4'h1,
    IID_THRE    = 4'h2,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_TIMEOUT = 4'hC
  } iid_e;

  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_OUT2 = 3;
  localparam int MC_LOOP = 4;

  localparam int MS_DCTS = 0;
  localparam int MS_DDSR = 1;
  localparam int MS_TERI = 2;
  localparam int MS_DDCD = 3;
  localparam int MS_CTS  = 4;
  localparam int MS_DSR  = 5;
  localparam int MS_RI   = 6;
  localparam int MS_DCD  = 7;
endpackage

// File: rtl/irq_timeout_ctr.sv
module irq_timeout_ctr #(
  parameter int CT_W    = 8,
  parameter int TO_MULT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            data_ready,
  input  logic            clr,
  input  logic [CT_W-1:0] char_time,
  output logic            timed_out
);
  localparam int MUL_W = $clog2(TO_MULT + 1);
  localparam int TW    = CT_W + MUL_W;

  function automatic logic [TW-1:0] to_limit(input logic [CT_W-1:0] ct);
    return TW'(ct) * TW'(TO_MULT);
  endfunction

  logic [TW-1:0] cnt;
  wire           at_max = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (data_ready && !at_max) cnt <= cnt + 1'b1;
  end

  assign timed_out = cnt >= to_limit(char_time);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !clr && !at_max) |=> cnt == $past(cnt) + 1'b1);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !clr) |=> $stable(cnt));
endmodule

// File: rtl/irq_thre_flag.sv
module irq_thre_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pending <= 1'b0;
    else if (load)  pending <= 1'b1;
    else if (clear) pending <= 1'b0;
  end

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pending);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !load) |=> !pending);
endmodule

// File: rtl/irq_modem_status.sv
module irq_modem_status
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] mcr,
  input  logic       rd,
  output logic [7:0] msr,
  output logic       delta_any
);
  logic [7:0] lvl_next;
  logic [7:0] msr_loop;

  always_comb begin
    lvl_next          = '0;
    lvl_next[MS_DCD]  = mcr[MC_OUT2];
    lvl_next[MS_RI]   = mcr[MC_OUT1];
    lvl_next[MS_DSR]  = mcr[MC_DTR];
    lvl_next[MS_CTS]  = mcr[MC_RTS];
    msr_loop          = {lvl_next[7:4], msr[3:0]};
    msr_loop[MS_DDCD] = msr[MS_DDCD] | (lvl_next[MS_DCD] ^ msr[MS_DCD]);
    msr_loop[MS_TERI] = msr[MS_TERI] | (msr[MS_RI] & ~lvl_next[MS_RI]);
    msr_loop[MS_DDSR] = msr[MS_DDSR] | (lvl_next[MS_DSR] ^ msr[MS_DSR]);
    msr_loop[MS_DCTS] = msr[MS_DCTS] | (lvl_next[MS_CTS] ^ msr[MS_CTS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            msr <= '0;
    else if (rd)           msr <= '0;
    else if (mcr[MC_LOOP]) msr <= msr_loop;
  end

  assign delta_any = |msr[3:0];

  p_read_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> msr == 8'h00);
  p_no_loop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !mcr[MC_LOOP]) |=> $stable(msr));
  p_ri_trailing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && mcr[MC_LOOP] && msr[MS_RI] && !mcr[MC_OUT1]) |=> msr[MS_TERI]);
  p_cts_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && mcr[MC_LOOP]) |=> msr[MS_CTS] == $past(mcr[MC_RTS]));
endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       ier,
  input  logic             line_err,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             timed_out,
  input  logic             thr_empty,
  input  logic             thre_pend,
  input  logic             msr_delta,
  output iid_e             code
);
  function automatic logic [CNT_W-1:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(4);
      2'd2:    return CNT_W'(8);
      default: return CNT_W'(14);
    endcase
  endfunction

  wire src_line = ier[2] && line_err;
  wire src_rx   = ier[0] && data_ready && (rx_count >= trig_level(trig_sel));
  wire src_to   = ier[0] && timed_out;
  wire src_thre = ier[1] && thr_empty && thre_pend;
  wire src_msr  = ier[3] && msr_delta;

  always_comb begin
    if (src_line)      code = IID_LINE;
    else if (src_rx)   code = IID_RXDATA;
    else if (src_to)   code = IID_TIMEOUT;
    else if (src_thre) code = IID_THRE;
    else if (src_msr)  code = IID_MODEM;
    else               code = IID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CT_W       = 8,
  parameter int TO_MULT    = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ier_i,
  input  logic [3:0]       lsr_err_i,
  input  logic             data_ready_i,
  input  logic             thr_empty_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CT_W-1:0]  char_time_i,
  input  logic [4:0]       mcr_i,
  input  logic             hold_load_i,
  input  logic             hold_write_i,
  input  logic             iir_read_i,
  input  logic             rbr_read_i,
  input  logic             rx_push_i,
  input  logic             msr_read_i,
  output logic [7:0]       iir_o,
  output logic [7:0]       msr_o,
  output logic             irq_o
);
  logic timed_out;
  logic thre_pend;
  logic msr_delta;
  iid_e code;

  wire to_clear   = rbr_read_i | rx_push_i;
  wire thre_clear = hold_write_i | iir_read_i;

  irq_timeout_ctr #(.CT_W(CT_W), .TO_MULT(TO_MULT)) u_timeout (
    .clk(clk), .rst_n(rst_n), .data_ready(data_ready_i), .clr(to_clear),
    .char_time(char_time_i), .timed_out(timed_out)
  );

  irq_thre_flag u_thre (
    .clk(clk), .rst_n(rst_n), .load(hold_load_i), .clear(thre_clear),
    .pending(thre_pend)
  );

  irq_modem_status u_msr (
    .clk(clk), .rst_n(rst_n), .mcr(mcr_i), .rd(msr_read_i),
    .msr(msr_o), .delta_any(msr_delta)
  );

  irq_prioritizer #(.CNT_W(CNT_W)) u_prio (
    .ier(ier_i), .line_err(|lsr_err_i), .data_ready(data_ready_i),
    .rx_count(rx_count_i), .trig_sel(trig_sel_i), .timed_out(timed_out),
    .thr_empty(thr_empty_i), .thre_pend(thre_pend), .msr_delta(msr_delta),
    .code(code)
  );

  assign iir_o = {4'b1100, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= (code != IID_NONE);
  end

  p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_i[2] && |lsr_err_i) |-> iir_o[3:0] == 4'h6);
  p_modem_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_i[3]) |-> iir_o[3:0] != 4'h0);
  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_o[0] == 1'b0) |=> irq_o);
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  localparam int FD = 16, CTW = 6, TOM = 2;
  localparam int CW = $clog2(FD + 1);
  localparam int CNT_MAX = (1 << (CTW + $clog2(TOM + 1))) - 1;

  logic clk = 0, rst_n = 0;
  logic [3:0] ier = 0, lsr_err = 0;
  logic dr = 0, thr_empty = 0;
  logic [CW-1:0] rx_count = 0;
  logic [1:0] trig_sel = 0;
  logic [CTW-1:0] char_time = 6'd60;
  logic [4:0] mcr = 0;
  logic hold_load = 0, hold_write = 0, iir_read = 0, rbr_read = 0, rx_push = 0, msr_read = 0;
  logic [7:0] iir, msr;
  logic irq;

  int n_total = 0, n_fail = 0;
  int m_pend = 0, m_cnt = 0, m_msr = 0, m_irq = 0;

  always #4 clk = ~clk;

  uart_irq_ident #(.FIFO_DEPTH(FD), .CT_W(CTW), .TO_MULT(TOM)) uut (
    .clk(clk), .rst_n(rst_n), .ier_i(ier), .lsr_err_i(lsr_err),
    .data_ready_i(dr), .thr_empty_i(thr_empty), .rx_count_i(rx_count),
    .trig_sel_i(trig_sel), .char_time_i(char_time), .mcr_i(mcr),
    .hold_load_i(hold_load), .hold_write_i(hold_write), .iir_read_i(iir_read),
    .rbr_read_i(rbr_read), .rx_push_i(rx_push), .msr_read_i(msr_read),
    .iir_o(iir), .msr_o(msr), .irq_o(irq)
  );

  function automatic int trig_of(int s);
    int lv[4] = '{1, 4, 8, 14};
    return lv[s];
  endfunction

  function automatic int exp_code();
    if (ier[2] && lsr_err != 0) return 6;
    if (ier[0] && dr && int'(rx_count) >= trig_of(int'(trig_sel))) return 4;
    if (ier[0] && m_cnt >= TOM * int'(char_time)) return 12;
    if (ier[1] && thr_empty && m_pend != 0) return 2;
    if (ier[3] && (m_msr & 15) != 0) return 0;
    return 1;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      6: return "R2"; 4: return "R3"; 12: return "R4";
      2: return "R5"; 0: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic chk(int got, int exp, string tag, string what);
    n_total++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // reference model state, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_cnt = 0; m_msr = 0; m_irq = 0;
    end else begin
      int c, lv, d;
      c = exp_code();
      m_irq = (c != 1);
      if (hold_load) m_pend = 1;
      else if (hold_write || iir_read) m_pend = 0;
      if (rbr_read || rx_push) m_cnt = 0;
      else if (dr && m_cnt < CNT_MAX) m_cnt++;
      if (msr_read) m_msr = 0;
      else if (mcr[4]) begin
        lv = (int'(mcr[3]) << 7) | (int'(mcr[2]) << 6) | (int'(mcr[0]) << 5) | (int'(mcr[1]) << 4);
        d = m_msr & 15;
        if (((lv ^ m_msr) >> 7) & 1) d |= 8;
        if (((m_msr >> 6) & 1) && !((lv >> 6) & 1)) d |= 4;
        if (((lv ^ m_msr) >> 5) & 1) d |= 2;
        if (((lv ^ m_msr) >> 4) & 1) d |= 1;
        m_msr = lv | d;
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int c;
      c = exp_code();
      chk(int'(iir), 8'hC0 | c, tag_of(c), "model iir");
      chk(int'(msr), m_msr, "R10", "model msr");
      chk(int'(irq), m_irq, "R8", "model irq");
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic strobes_off();
    hold_load = 0; hold_write = 0; iir_read = 0; rbr_read = 0; rx_push = 0; msr_read = 0;
  endtask

  initial begin
    #800000;
    n_total++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    #1;
    chk(int'(iir), 8'hC1, "R1", "reset iir");
    chk(int'(msr), 0, "R1", "reset msr");
    chk(int'(irq), 0, "R1", "reset irq");
    tick();

    // holding empty pending flag
    ier = 4'b0010; thr_empty = 1;
    hold_load = 1; tick(); hold_load = 0;
    chk(int'(iir), 8'hC2, "R5", "pending after load");
    tick();
    chk(int'(irq), 1, "R8", "irq one clock later");
    iir_read = 1; tick(); iir_read = 0;
    chk(int'(iir), 8'hC1, "R5", "cleared by iir read");
    tick();
    chk(int'(irq), 0, "R8", "irq drops");
    hold_load = 1; hold_write = 1; tick(); strobes_off();
    chk(int'(iir), 8'hC2, "R5", "set wins over write");
    hold_write = 1; tick(); strobes_off();
    chk(int'(iir), 8'hC1, "R5", "cleared by write");
    chk(int'(iir[7:4]), 4'hC, "R7", "upper bits");

    // received data trigger levels
    ier = 4'b0001; dr = 1; rx_push = 1; tick(); rx_push = 0;
    trig_sel = 1; rx_count = 3; #1;
    chk(int'(iir), 8'hC1, "R3", "below level 4");
    rx_count = 4; #1;
    chk(int'(iir), 8'hC4, "R3", "at level 4");
    trig_sel = 3; rx_count = 13; #1;
    chk(int'(iir), 8'hC1, "R3", "below level 14");
    rx_count = 14; #1;
    chk(int'(iir), 8'hC4, "R3", "at level 14");
    trig_sel = 2; rx_count = 8; #1;
    chk(int'(iir), 8'hC4, "R3", "at level 8");
    trig_sel = 0; rx_count = 1; #1;
    chk(int'(iir), 8'hC4, "R3", "at level 1");
    ier = 4'b0101; lsr_err = 4'b0010; #1;
    chk(int'(iir), 8'hC6, "R2", "line status over data");
    lsr_err = 4'b1000; ier = 4'b0001; #1;
    chk(int'(iir), 8'hC4, "R2", "line status disabled");
    lsr_err = 0;
    tick();

    // character timeout, limit 2*3 = 6 clocks
    char_time = 3; rx_count = 0; trig_sel = 1;
    rx_push = 1; tick(); rx_push = 0;
    tick(5);
    chk(int'(iir), 8'hC1, "R4", "five clocks no timeout");
    tick();
    chk(int'(iir), 8'hCC, "R4", "timeout at limit");
    dr = 0; tick(4);
    chk(int'(iir), 8'hCC, "R4", "counter holds without data-ready");
    rbr_read = 1; tick(); rbr_read = 0;
    chk(int'(iir), 8'hC1, "R4", "cleared by buffer read");
    rx_push = 1; dr = 1; tick(); rx_push = 0; dr = 0;
    chk(int'(iir), 8'hC1, "R4", "push wins over increment");
    char_time = 60; tick();

    // modem status in loopback
    ier = 4'b1000; mcr = 5'b10000; tick();
    chk(int'(msr), 0, "R9", "loopback idle");
    chk(int'(iir), 8'hC1, "R6", "no modem delta");
    mcr = 5'b10010; tick();
    chk(int'(msr), 8'h11, "R9", "RTS to CTS with delta");
    chk(int'(iir), 8'hC0, "R6", "modem source");
    ier = 4'b1010; thr_empty = 1; hold_load = 1; tick(); hold_load = 0;
    chk(int'(iir), 8'hC2, "R6", "modem below holding empty");
    iir_read = 1; tick(); iir_read = 0; ier = 4'b1000;
    msr_read = 1; tick(); msr_read = 0;
    chk(int'(msr), 0, "R11", "read clears all");
    tick();
    chk(int'(msr), 8'h11, "R10", "delta after clear");
    mcr = 5'b10110; tick();
    chk(int'(msr), 8'h51, "R10", "RI rise sets no delta");
    mcr = 5'b10010; tick();
    chk(int'(msr), 8'h15, "R10", "RI fall sets trailing delta");
    mcr = 5'b11011; tick();
    chk(int'(msr), 8'hBF, "R9", "OUT2 to DCD, DTR to DSR");
    mcr = 5'b01000; tick(3);
    chk(int'(msr), 8'hBF, "R11", "no change outside loopback");
    msr_read = 1; tick(); msr_read = 0;
    chk(int'(msr), 0, "R11", "read clears outside loopback");

    // random phase against the model
    for (int i = 0; i < 600; i++) begin
      ier = 4'($urandom); lsr_err = ($urandom % 8 == 0) ? 4'($urandom) : 4'd0;
      dr = 1'($urandom); thr_empty = 1'($urandom);
      rx_count = CW'($urandom % (FD + 1)); trig_sel = 2'($urandom);
      char_time = CTW'(1 + $urandom % 7); mcr = 5'($urandom);
      hold_load = ($urandom % 4 == 0); hold_write = ($urandom % 5 == 0);
      iir_read = ($urandom % 5 == 0); rbr_read = ($urandom % 9 == 0);
      rx_push = ($urandom % 9 == 0); msr_read = ($urandom % 6 == 0);
      tick();
    end
    strobes_off();
    tick(2);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule